// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the interrupt entry and return sequences for a small 8-bit processor core with a 16-bit address space. At an instruction boundary it may accept a non-maskable interrupt or a level-sensitive maskable interrupt. On acceptance it saves the program counter and the flag byte to a stack that grows downward, reads a two-byte vector, and hands the new program counter, stack pointer and flags back to the core. When the core signals a return-from-interrupt, the block pops the flags and the program counter and hands them back in the same way.

The core owns its PC, SP and flag registers and presents them on the inputs. The sequencer drives a byte-wide memory bus whose read data arrives in the same cycle as the read strobe. It raises `busy` while it owns the bus, so that the core holds off instruction fetch. At the end it pulses three load strobes together, and the core copies the offered values into its registers on that clock edge.

Top module: `intr_seq`

## Requirements
- R1: After reset, `busy`, `mem_rd`, `mem_wr` and all three load strobes are low until an acceptance occurs.
- R2: An entry writes three bytes, each at one below the previous address: the PC high byte at SP-1, the PC low byte at SP-2, and the flag byte at SP-3. It then offers SP-3 as the new SP. When SP starts at 0x6000, the writes land at 0x5FFF, 0x5FFE and 0x5FFD.
- R3: A high `irq_lvl` is accepted only while flag bit 2 (the mask bit) is 0. Its vector's low byte is read from 0xFFFC and its high byte from 0xFFFD. While bit 2 is 1 the request causes no bus activity.
- R4: An NMI is accepted regardless of flag bit 2. Its vector's low byte is read from 0xFFFA and its high byte from 0xFFFB.
- R5: Each rising edge of `nmi_in` causes exactly one entry, even if the line stays high afterwards.
- R6: When several requests meet at one boundary, NMI wins over IRQ, and IRQ wins over a return request.
- R7: An entry offers the saved flag byte with bit 2 forced to 1, while the byte written to the stack is the unmodified original. A later return restores that original.
- R8: A return reads the flags at SP, the PC low byte at SP+1 and the PC high byte at SP+2, then offers PC = {high, low} and SP+3.
- R9: `busy` is high in the accepting cycle, then for 5 more cycles on an entry or 3 more on a return. All three load strobes pulse together only in the last busy cycle.
- R10: Acceptance needs `boundary` high while the block is idle. A `boundary` or `rti_req` asserted while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | 1 | Maskable interrupt request, level |
| nmi_in | input | 1 | Non-maskable interrupt line, rising edge |
| boundary | input | 1 | Core is at an instruction boundary |
| rti_req | input | 1 | Core is executing a return-from-interrupt (with `boundary`) |
| pc_in | input | 16 | Core's current program counter |
| sp_in | input | 16 | Core's current stack pointer |
| flags_in | input | 8 | Core's flag byte; bit 2 masks IRQ |
| busy | output | 1 | Sequencer owns the bus; core stalls fetch |
| pc_load | output | 1 | Load `pc_out` into the core PC |
| pc_out | output | 16 | New program counter |
| sp_load | output | 1 | Load `sp_out` into the core SP |
| sp_out | output | 16 | New stack pointer |
| flags_load | output | 1 | Load `flags_out` into the core flags |
| flags_out | output | 8 | New flag byte |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |

## Verification
The assertions assume the following about the environment:
- `mem_rdata` is valid combinationally during any read.
- The core copies the offered PC, SP and flags exactly on the load edge and keeps `pc_in`, `sp_in` and `flags_in` steady while the block is busy.
- SP starts at or below 0x6000, so that stack writes fall below that address.

The stimulus drives every input at the falling clock edge. The bench core model updates its registers only on `pc_load`, and the bench always lowers `nmi_in` for at least one clock before raising it again. The bench's memory model returns data without delay.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] byte_t;

  typedef enum logic [3:0] {
    S_IDLE, S_PCH, S_PCL, S_FLG, S_VLO, S_VHI, S_RFLG, S_RPCL, S_RPCH
  } seq_state_e;

  // descending stack: a push uses the slot one below the current pointer
  function automatic addr_t push_slot(addr_t sp);
    return sp - addr_t'(1);
  endfunction

  function automatic addr_t pop_next(addr_t sp);
    return sp + addr_t'(1);
  endfunction

  function automatic addr_t join_word(byte_t hi, byte_t lo);
    return {hi, lo};
  endfunction

  function automatic byte_t hi_byte(addr_t w);
    return w[AW-1:DW];
  endfunction

  function automatic byte_t lo_byte(addr_t w);
    return w[DW-1:0];
  endfunction

  function automatic byte_t force_bit(byte_t f, int unsigned b);
    byte_t r;
    r = f;
    r[b] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic clr,
  output logic pend
);
  logic prev_q, pend_q, rise;

  assign rise = nmi_in & ~prev_q;
  assign pend = pend_q | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_in;
      pend_q <= pend & ~clr;
    end
  end

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

  // R5
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && $past(nmi_in) && nmi_in) |=> !$rose(pend_q));
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter (
  input  logic idle,
  input  logic boundary,
  input  logic nmi_pend,
  input  logic irq_lvl,
  input  logic imask,
  input  logic rti_req,
  output logic take_nmi,
  output logic take_irq,
  output logic take_rti
);
  logic slot, irq_ok;

  assign slot     = idle & boundary;
  assign irq_ok   = irq_lvl & ~imask;
  assign take_nmi = slot & nmi_pend;
  assign take_irq = slot & ~nmi_pend & irq_ok;
  assign take_rti = slot & ~nmi_pend & ~irq_ok & rti_req;
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_seq_pkg::*;
#(
  parameter int unsigned I_BIT     = 2,
  parameter logic [15:0] NMI_VEC   = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC   = 16'hFFFC,
  parameter logic [15:0] STACK_TOP = 16'h6000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_lvl,
  input  logic        nmi_in,
  input  logic        boundary,
  input  logic        rti_req,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  input  logic [7:0]  flags_in,
  output logic        busy,
  output logic        pc_load,
  output logic [15:0] pc_out,
  output logic        sp_load,
  output logic [15:0] sp_out,
  output logic        flags_load,
  output logic [7:0]  flags_out,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  seq_state_e st;
  addr_t pc_r, sp_r, vec_r;
  byte_t flg_r, lo_r;
  logic  nmi_pend, take_nmi, take_irq, take_rti, take_ent;
  logic  idle, push_phase, ent_load, ret_load;

  assign idle       = (st == S_IDLE);
  assign take_ent   = take_nmi | take_irq;
  assign push_phase = (st == S_PCH) | (st == S_PCL) | (st == S_FLG);
  assign ent_load   = (st == S_VHI);
  assign ret_load   = (st == S_RPCH);

  intr_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .clr(take_nmi), .pend(nmi_pend)
  );

  intr_arbiter u_arb (
    .idle(idle), .boundary(boundary), .nmi_pend(nmi_pend), .irq_lvl(irq_lvl),
    .imask(flags_in[I_BIT]), .rti_req(rti_req),
    .take_nmi(take_nmi), .take_irq(take_irq), .take_rti(take_rti)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pc_r  <= '0;
      sp_r  <= '0;
      vec_r <= '0;
      flg_r <= '0;
      lo_r  <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (take_ent) begin
            pc_r  <= pc_in;
            sp_r  <= sp_in;
            flg_r <= flags_in;
            vec_r <= take_nmi ? NMI_VEC : IRQ_VEC;
            st    <= S_PCH;
          end else if (take_rti) begin
            sp_r <= sp_in;
            st   <= S_RFLG;
          end
        end
        S_PCH:  begin sp_r <= push_slot(sp_r); st <= S_PCL; end
        S_PCL:  begin sp_r <= push_slot(sp_r); st <= S_FLG; end
        S_FLG:  begin sp_r <= push_slot(sp_r); st <= S_VLO; end
        S_VLO:  begin lo_r <= mem_rdata; st <= S_VHI; end
        S_VHI:  st <= S_IDLE;
        S_RFLG: begin flg_r <= mem_rdata; sp_r <= pop_next(sp_r); st <= S_RPCL; end
        S_RPCL: begin lo_r <= mem_rdata; sp_r <= pop_next(sp_r); st <= S_RPCH; end
        S_RPCH: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wr    = push_phase;
    mem_rd    = 1'b0;
    unique case (st)
      S_PCH: begin mem_addr = push_slot(sp_r); mem_wdata = hi_byte(pc_r); end
      S_PCL: begin mem_addr = push_slot(sp_r); mem_wdata = lo_byte(pc_r); end
      S_FLG: begin mem_addr = push_slot(sp_r); mem_wdata = flg_r; end
      S_VLO: begin mem_addr = vec_r; mem_rd = 1'b1; end
      S_VHI: begin mem_addr = pop_next(vec_r); mem_rd = 1'b1; end
      S_RFLG, S_RPCL, S_RPCH: begin mem_addr = sp_r; mem_rd = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    pc_load    = ent_load | ret_load;
    sp_load    = pc_load;
    flags_load = pc_load;
    pc_out     = pc_load ? join_word(mem_rdata, lo_r) : '0;
    sp_out     = ent_load ? sp_r : (ret_load ? pop_next(sp_r) : '0);
    flags_out  = ent_load ? force_bit(flg_r, I_BIT) : (ret_load ? flg_r : '0);
  end

  assign busy = ~idle | take_ent | take_rti;

  // R2
  push_below_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && sp_in <= STACK_TOP) |-> (mem_addr < STACK_TOP));

  // R2
  push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - 16'd1));

  // R2
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R6
  arb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi, take_irq, take_rti}));

  // R7
  entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_load |-> (flags_out == ($past(mem_wdata, 2) | (8'd1 << I_BIT))));

  // R8
  ret_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_load |-> (sp_out == $past(mem_addr, 2) + 16'd3));

  // R9
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (busy && sp_load && flags_load));

  // R9
  load_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (st == S_IDLE));
endmodule

// File: tb/intr_seq_tb.sv
module intr_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_lvl = 1'b0, nmi_in = 1'b0, boundary = 1'b0, rti_req = 1'b0;
  logic [15:0] pc = 16'h0123, sp = 16'h6000;
  logic [7:0]  flags = 8'h00;
  logic        busy, pc_load, sp_load, flags_load, mem_rd, mem_wr;
  logic [15:0] pc_out, sp_out, mem_addr;
  logic [7:0]  flags_out, mem_wdata, mem_rdata;
  logic [7:0]  stk [0:255];
  logic [7:0]  exp_stk [0:255];
  int nchk = 0, nfail = 0;

  typedef struct {
    int          kind;   // 1 write, 2 read, 3 register load
    logic [15:0] a;
    logic [15:0] s;
    logic [7:0]  d;
    string       tg;
  } ev_t;
  ev_t q[$];

  always #5 clk = ~clk;

  intr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .nmi_in(nmi_in),
    .boundary(boundary), .rti_req(rti_req), .pc_in(pc), .sp_in(sp),
    .flags_in(flags), .busy(busy), .pc_load(pc_load), .pc_out(pc_out),
    .sp_load(sp_load), .sp_out(sp_out), .flags_load(flags_load),
    .flags_out(flags_out), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] vec_byte(logic [15:0] a);
    case (a)
      16'hFFFA: return 8'h34;
      16'hFFFB: return 8'h12;
      16'hFFFC: return 8'h78;
      16'hFFFD: return 8'h56;
      default:  return 8'h00;
    endcase
  endfunction

  always_comb begin
    if (mem_addr[15:8] == 8'h5F) mem_rdata = stk[mem_addr[7:0]];
    else mem_rdata = vec_byte(mem_addr);
  end

  // core model and memory
  always @(posedge clk) begin
    if (mem_wr && mem_addr[15:8] == 8'h5F) stk[mem_addr[7:0]] <= mem_wdata;
    if (pc_load) begin
      pc    <= pc_out;
      sp    <= sp_out;
      flags <= flags_out;
    end
  end

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tg, act, exp);
    end
  endtask

  task automatic push_ev(input int k, input logic [15:0] a, input logic [15:0] s,
                         input logic [7:0] d, input string tg);
    ev_t e;
    e.kind = k; e.a = a; e.s = s; e.d = d; e.tg = tg;
    q.push_back(e);
  endtask

  task automatic see(input int k, input logic [15:0] a, input logic [15:0] s, input logic [7:0] d);
    ev_t e;
    bit ok;
    if (q.size() == 0) begin
      chk(1'b0, "R10 unexpected bus event", {k[3:0], 12'h0, a}, 32'h0);
    end else begin
      e = q.pop_front();
      ok = (e.kind == k) && (e.a == a) && (k != 3 || e.s == s) && (k == 2 || e.d == d);
      chk(ok, e.tg, {k[3:0], a, d[7:0], 4'h0}, {e.kind[3:0], e.a, e.d, 4'h0});
      if (!ok && k == 3) $display("  load sp actual %h expected %h", s, e.s);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr)  see(1, mem_addr, 16'h0, mem_wdata);
      if (mem_rd)  see(2, mem_addr, 16'h0, 8'h0);
      if (pc_load) see(3, pc_out, sp_out, flags_out);
    end
  end

  task automatic exp_entry(input bit nmi, input string tg);
    logic [15:0] v, a1, a2, a3;
    v  = nmi ? 16'hFFFA : 16'hFFFC;
    a1 = sp - 16'd1; a2 = sp - 16'd2; a3 = sp - 16'd3;
    push_ev(1, a1, 16'h0, pc[15:8], tg);
    push_ev(1, a2, 16'h0, pc[7:0], tg);
    push_ev(1, a3, 16'h0, flags, tg);
    exp_stk[a1[7:0]] = pc[15:8];
    exp_stk[a2[7:0]] = pc[7:0];
    exp_stk[a3[7:0]] = flags;
    push_ev(2, v, 16'h0, 8'h0, tg);
    push_ev(2, v + 16'd1, 16'h0, 8'h0, tg);
    push_ev(3, {vec_byte(v + 16'd1), vec_byte(v)}, a3, flags | 8'h04, tg);
  endtask

  task automatic exp_rti(input string tg);
    logic [15:0] a1, a2;
    a1 = sp + 16'd1; a2 = sp + 16'd2;
    push_ev(2, sp, 16'h0, 8'h0, tg);
    push_ev(2, a1, 16'h0, 8'h0, tg);
    push_ev(2, a2, 16'h0, 8'h0, tg);
    push_ev(3, {exp_stk[a2[7:0]], exp_stk[a1[7:0]]}, sp + 16'd3, exp_stk[sp[7:0]], tg);
  endtask

  // one boundary pulse (held for extra cycles when hold > 0); counts busy cycles
  task automatic run_op(input bit r, input int hold, input int exp_cnt, input string tg);
    int cnt;
    @(negedge clk); boundary = 1'b1; rti_req = r; #1;
    cnt = busy ? 1 : 0;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk); #1;
      if (busy) cnt++;
    end
    @(negedge clk); boundary = 1'b0; rti_req = 1'b0; #1;
    while (busy) begin
      cnt++;
      @(negedge clk); #1;
    end
    chk(cnt == exp_cnt, {tg, " R9 busy length"}, cnt, exp_cnt);
    chk(q.size() == 0, {tg, " events left"}, q.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !mem_rd && !mem_wr, "R1 strobes in reset", {busy, mem_rd, mem_wr}, 0);
    chk(!pc_load && !sp_load && !flags_load, "R1 loads in reset", {pc_load, sp_load, flags_load}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !mem_rd && !mem_wr && !pc_load, "R1 after reset", {busy, mem_rd, mem_wr, pc_load}, 0);

    // R10: unmasked IRQ without a boundary is not taken
    irq_lvl = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk(!busy, "R10 no boundary", busy, 0);

    // R2/R3: IRQ entry from SP 0x6000
    exp_entry(1'b0, "R2 R3 irq entry");
    run_op(1'b0, 0, 6, "R3");
    chk(pc == 16'h5678 && sp == 16'h5FFD, "R3 core state", {pc, sp}, {16'h5678, 16'h5FFD});

    // R3: mask bit now set, IRQ still high
    run_op(1'b0, 0, 0, "R3 masked");

    // R4: NMI ignores the mask
    @(negedge clk); nmi_in = 1'b1;
    exp_entry(1'b1, "R4 nmi entry");
    run_op(1'b0, 0, 6, "R4");

    // R5: line held high gives no second entry
    run_op(1'b0, 0, 0, "R5 held nmi");

    // R8: return from the nested NMI
    exp_rti("R8 return");
    run_op(1'b1, 0, 4, "R8");
    chk(pc == 16'h5678 && sp == 16'h5FFD && flags == 8'h04, "R8 core state",
        {pc, sp}, {16'h5678, 16'h5FFD});

    // R7: second return restores the original flag byte
    irq_lvl = 1'b0;
    exp_rti("R7 return");
    run_op(1'b1, 0, 4, "R7");
    chk(flags == 8'h00 && sp == 16'h6000 && pc == 16'h0123, "R7 flags restored",
        {flags, sp}, {8'h00, 16'h6000});

    // R6: fresh NMI edge and unmasked IRQ together, NMI wins
    @(negedge clk); nmi_in = 1'b0;
    @(negedge clk); nmi_in = 1'b1; irq_lvl = 1'b1;
    exp_entry(1'b1, "R6 nmi over irq");
    run_op(1'b0, 0, 6, "R6");
    exp_rti("R6 return");
    run_op(1'b1, 0, 4, "R6 ret");

    // R6/R10: IRQ beats a return request; boundary held during busy is ignored
    exp_entry(1'b0, "R10 irq over rti");
    run_op(1'b1, 2, 6, "R10");
    irq_lvl = 1'b0;
    exp_rti("R10 return");
    run_op(1'b1, 0, 4, "R10 ret");
    chk(pc == 16'h0123 && sp == 16'h6000, "R10 final state", {pc, sp}, {16'h0123, 16'h6000});

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule